// File: doc/BRIEF.md
# CAN Frame CRC-15 Checksum Unit

This block keeps the 15-bit frame checksum of a CAN controller. The framing logic gives it one destuffed bit at a time with a valid strobe. Each accepted bit updates a 15-bit remainder register. A synchronous clear empties the register before the start-of-frame bit. Stuff bits are never presented, so they never affect the checksum.

A phase input marks the bits of the checksum field. On the transmit side, the framing logic raises that phase after the data field. The unit then presents the remainder most significant bit first on a serial output and fills the register with zeros, over fifteen bit times. On the receive side, the fifteen received checksum bits pass through the same update as the data. A zero remainder after the last of them means the frame is good. The result is held for the fault-confinement logic until the next clear.

Top module: `can_crc15_unit`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is high, `crc_o` is 0 and `crc_done_o` and `crc_ok_o` are 0. When `clear_i` and `bit_valid_i` are high in the same cycle, the clear wins and the bit is dropped.
- R2: Outside the transmit checksum phase, each accepted bit updates the remainder as follows. Form f = `bit_i` XOR `crc_o[14]`. Shift left by one with a zero entering bit 0. XOR in 15'h4599 when f is 1. Fed with the ASCII bytes of "123456789", each byte most significant bit first, the remainder is 15'h059E.
- R3: A cycle with `bit_valid_i` low leaves `crc_o` unchanged, whatever the values of `bit_i` and the other inputs.
- R4: In receive mode (`mode_tx_i` = 0), valid bits with `crc_phase_i` = 1 go through the R2 update and are counted. `crc_done_o` stays 0 until the fifteenth such bit. In the cycle after that bit, `crc_done_o` is 1 and `crc_ok_o` is 1 exactly when the remainder is zero.
- R5: In transmit mode (`mode_tx_i` = 1), each valid bit with `crc_phase_i` = 1 does three things. `tx_bit_o` already equals `crc_o[14]`. The register shifts left with a zero in. `bit_i` is ignored. After fifteen such bits, `tx_bit_o` has carried the whole remainder most significant bit first, `crc_o` is 0, `crc_done_o` is 1 and `crc_ok_o` stays 0.
- R6: Once `crc_done_o` is 1, further valid bits are ignored. `crc_o`, `crc_done_o` and `crc_ok_o` hold until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous start-of-frame clear |
| mode_tx_i | input | 1 | 1 = transmit, 0 = receive |
| bit_valid_i | input | 1 | Strobe for a destuffed bit |
| bit_i | input | 1 | Destuffed bit value |
| crc_phase_i | input | 1 | Presented bit belongs to the checksum field |
| crc_o | output | 15 | Current remainder |
| tx_bit_o | output | 1 | Serial checksum output, equal to the remainder MSB |
| crc_done_o | output | 1 | Checksum field complete |
| crc_ok_o | output | 1 | Received checksum matched |

## Verification
Two events can fall in the same cycle: a clear for a new frame, and a valid bit left over from the old one. The bench raises `clear_i` and `bit_valid_i` together in two situations: on a dirty remainder, and on a finished receive check with its result flags set. It judges the outcome by reading a zero remainder and low flags on the next cycle. A second overlap is a valid bit that arrives in the same cycle `crc_done_o` becomes visible. The bench keeps the strobe high past the fifteenth checksum bit and checks that the remainder and the flags do not move.

// File: rtl/can_crc_pkg.sv
package can_crc_pkg;
  parameter int unsigned CRC_W = 15;
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int unsigned CNT_W = $clog2(CRC_W + 1);

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_POLY  = 2'd2,
    OP_SHIFT = 2'd3
  } crc_op_e;
endpackage

// File: rtl/crc15_reg.sv
module crc15_reg
  import can_crc_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  crc_op_e      op_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_q_o,
  output logic [W-1:0] crc_d_o
);
  logic [W-1:0] crc_q, crc_poly;
  logic         fb;

  assign fb = bit_i ^ crc_q[W-1];

  // per-bit tap selection
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign crc_poly[i] = fb & POLY[i];
    end else begin : g_up
      assign crc_poly[i] = crc_q[i-1] ^ (fb & POLY[i]);
    end
  end

  always_comb begin
    unique case (op_i)
      OP_CLEAR: crc_d_o = '0;
      OP_POLY:  crc_d_o = crc_poly;
      OP_SHIFT: crc_d_o = {crc_q[W-2:0], 1'b0};
      default:  crc_d_o = crc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d_o;
  end

  assign crc_q_o = crc_q;
endmodule

// File: rtl/crc15_ctrl.sv
module crc15_ctrl
  import can_crc_pkg::*;
#(
  parameter int unsigned W = CRC_W
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clear_i,
  input  logic    mode_tx_i,
  input  logic    bit_valid_i,
  input  logic    crc_phase_i,
  input  logic    next_zero_i,
  output crc_op_e op_o,
  output logic    done_o,
  output logic    ok_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q, ok_q, take, tx_shift, field_bit;

  assign take      = bit_valid_i & ~done_q & ~clear_i;
  assign tx_shift  = crc_phase_i & mode_tx_i;
  assign field_bit = take & crc_phase_i;

  always_comb begin
    if (clear_i)       op_o = OP_CLEAR;
    else if (!take)    op_o = OP_HOLD;
    else if (tx_shift) op_o = OP_SHIFT;
    else               op_o = OP_POLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (field_bit) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        done_q <= 1'b1;
        ok_q   <= ~mode_tx_i & next_zero_i;
      end
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
endmodule

// File: rtl/can_crc15_unit.sv
module can_crc15_unit
  import can_crc_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         mode_tx_i,
  input  logic         bit_valid_i,
  input  logic         bit_i,
  input  logic         crc_phase_i,
  output logic [W-1:0] crc_o,
  output logic         tx_bit_o,
  output logic         crc_done_o,
  output logic         crc_ok_o
);
  crc_op_e      op;
  logic [W-1:0] crc_q, crc_d;

  crc15_ctrl #(.W(W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .mode_tx_i   (mode_tx_i),
    .bit_valid_i (bit_valid_i),
    .crc_phase_i (crc_phase_i),
    .next_zero_i (crc_d == '0),
    .op_o        (op),
    .done_o      (crc_done_o),
    .ok_o        (crc_ok_o)
  );

  crc15_reg #(.W(W), .POLY(POLY)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .bit_i   (bit_i),
    .crc_q_o (crc_q),
    .crc_d_o (crc_d)
  );

  assign crc_o    = crc_q;
  assign tx_bit_o = crc_q[W-1];
endmodule

// File: rtl/can_crc15_checker.sv
module can_crc15_checker #(
  parameter int unsigned W = 15
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         mode_tx_i,
  input logic         bit_valid_i,
  input logic         crc_phase_i,
  input logic [W-1:0] crc_o,
  input logic         crc_done_o,
  input logic         crc_ok_o
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_o == '0) && !crc_done_o && !crc_ok_o); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !bit_valid_i) |=> $stable(crc_o)); // R3

  AST_OK_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ok_o |-> crc_done_o); // R4

  AST_OK_ZERO_REM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_ok_o) |-> (crc_o == '0)); // R4

  AST_TX_SHIFT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && bit_valid_i && crc_phase_i && mode_tx_i && !crc_done_o)
      |=> (crc_o[0] == 1'b0) && (crc_o[W-1:1] == $past(crc_o[W-2:0]))); // R5

  AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_done_o && !clear_i) |=> crc_done_o && $stable(crc_o) && $stable(crc_ok_o)); // R6
endmodule

bind can_crc15_unit can_crc15_checker #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .mode_tx_i   (mode_tx_i),
  .bit_valid_i (bit_valid_i),
  .crc_phase_i (crc_phase_i),
  .crc_o       (crc_o),
  .crc_done_o  (crc_done_o),
  .crc_ok_o    (crc_ok_o)
);

// File: tb/sim_can_crc15_unit.sv
`timescale 1ns/1ps
module sim_can_crc15_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, mode_tx_i = 1'b0, bit_valid_i = 1'b0;
  logic        bit_i = 1'b0, crc_phase_i = 1'b0;
  logic [14:0] crc_o;
  logic        tx_bit_o, crc_done_o, crc_ok_o;

  int checks = 0, fails = 0, cycles = 0;
  logic [14:0] model;

  always #2 clk_i = ~clk_i;

  can_crc15_unit u0 (.*);

  function automatic logic [14:0] ref_step(logic [14:0] r, logic b);
    logic f = b ^ r[14];
    return {r[13:0], 1'b0} ^ (f ? 15'h4599 : 15'h0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on negedge, one clock per call, outputs settled at return
  task automatic step(logic clr, logic v, logic b, logic ph);
    clear_i = clr; bit_valid_i = v; bit_i = b; crc_phase_i = ph;
    @(negedge clk_i);
    clear_i = 1'b0; bit_valid_i = 1'b0; crc_phase_i = 1'b0;
  endtask

  task automatic do_clear();
    step(1'b1, 1'b0, 1'b0, 1'b0);
    model = '0;
  endtask

  task automatic feed_byte(logic [7:0] by);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, 1'b1, by[i], 1'b0);
      model = ref_step(model, by[i]);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset crc", crc_o, 0);
    chk("R1 reset done", crc_done_o, 0);
    chk("R1 reset ok", crc_ok_o, 0);
  endtask

  task automatic t_vector();
    string s = "123456789";
    mode_tx_i = 1'b0;
    do_clear();
    for (int k = 0; k < 9; k++) feed_byte(s[k]);
    chk("R2 check vector", crc_o, 15'h059E);
  endtask

  task automatic t_pattern();
    do_clear();
    for (int i = 0; i < 40; i++) begin
      logic b = ((i * 7) % 5) < 2;
      step(1'b0, 1'b1, b, 1'b0);
      model = ref_step(model, b);
    end
    chk("R2 pattern", crc_o, model);
  endtask

  task automatic t_idle();
    logic [14:0] held = crc_o;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, i[0], i[1]);
    chk("R3 idle hold", crc_o, held);
  endtask

  task automatic t_rx(logic corrupt);
    logic [14:0] c;
    mode_tx_i = 1'b0;
    do_clear();
    feed_byte(8'hA5); feed_byte(8'h3C);
    c = model ^ (corrupt ? 15'h0010 : 15'h0);
    for (int i = 14; i >= 0; i--) begin
      step(1'b0, 1'b1, c[i], 1'b1);
      if (i == 1) chk("R4 done low before 15th", crc_done_o, 0);
    end
    chk("R4 done", crc_done_o, 1);
    chk(corrupt ? "R4 ok on mismatch" : "R4 ok on match", crc_ok_o, corrupt ? 0 : 1);
  endtask

  task automatic t_tx();
    logic [14:0] exp, got;
    mode_tx_i = 1'b1;
    do_clear();
    feed_byte(8'h5A); feed_byte(8'hF0); feed_byte(8'h01);
    exp = model;
    for (int i = 14; i >= 0; i--) begin
      got[i] = tx_bit_o;
      step(1'b0, 1'b1, 1'b1, 1'b1);
    end
    chk("R5 serial out", got, exp);
    chk("R5 remainder zero", crc_o, 0);
    chk("R5 done", crc_done_o, 1);
    chk("R5 ok low", crc_ok_o, 0);
    mode_tx_i = 1'b0;
  endtask

  task automatic t_after_done();
    logic [14:0] c;
    mode_tx_i = 1'b0;
    do_clear();
    feed_byte(8'h77);
    c = model;
    // strobe stays high past the last checksum bit
    for (int i = 14; i >= 0; i--) begin
      clear_i = 1'b0; bit_valid_i = 1'b1; bit_i = c[i]; crc_phase_i = 1'b1;
      @(negedge clk_i);
    end
    bit_i = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk_i);
    bit_valid_i = 1'b0; crc_phase_i = 1'b0;
    chk("R6 crc frozen", crc_o, 0);
    chk("R6 done held", crc_done_o, 1);
    chk("R6 ok held", crc_ok_o, 1);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R1 clear+valid crc", crc_o, 0);
    chk("R1 clear+valid done", crc_done_o, 0);
    chk("R1 clear+valid ok", crc_ok_o, 0);
  endtask

  task automatic t_clear_dirty();
    do_clear();
    feed_byte(8'hC3);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R1 clear beats bit", crc_o, 0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_vector();
    t_pattern();
    t_idle();
    t_rx(1'b0);
    t_rx(1'b1);
    t_tx();
    t_after_done();
    t_clear_dirty();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule